// File: doc/BRIEF.md
# Tracking Baseline Subtractor and Linearizer

This block conditions one digitizer channel at the sample clock. It holds a running estimate of the channel's resting level and takes that level away from every valid input sample. The difference is clamped into the unsigned 12-bit range. It then serves as the address into a 4096-entry calibration table, which turns the raw amplitude into a linearized one. The resting-level estimate moves only while the channel is quiet, so pulses do not pull it along.

Software or a loader loads the calibration table through a simple write port. It may do so while the channel is idle or while samples stream through. Samples enter with a valid strobe. Calibrated samples leave a fixed number of cycles later, with a matching valid strobe. The first valid sample after reset becomes the starting estimate.

Top module: `bline_cond`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `cal_vld_o` is 0.
- R2: `cal_vld_o` equals the `smp_vld_i` value sampled three rising edges earlier. Inputs captured at edge E produce their result after edge E+2.
- R3: For a valid sample, `cal_o` equals the table entry at address A. A is the sample minus the integer part of the estimate, clamped to 0..4095.
- R4: The first valid sample after reset loads the estimate with that sample (fraction zero), and its own address A is 0.
- R5: The estimate is 16 bits: 12 integer bits over 4 fraction bits. A later valid sample is quiet when its signed difference D = sample − integer estimate is below QUIET_THR (default 64). A quiet sample updates the estimate E to E + floor((sample·16 − E)/16).
- R6: A valid sample with D ≥ QUIET_THR leaves the estimate unchanged.
- R7: A negative difference D gives address 0.
- R8: Cycles with `smp_vld_i` low leave the estimate unchanged.
- R9: A table write with `tbl_we_i` high stores `tbl_data_i` at `tbl_addr_i` on the rising edge. Any sample captured in that same cycle or later looks up the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Input sample valid |
| smp_i | input | 12 | Raw unsigned input sample |
| tbl_we_i | input | 1 | Calibration table write enable |
| tbl_addr_i | input | 12 | Calibration table write address |
| tbl_data_i | input | 12 | Calibration table write data |
| cal_vld_o | output | 1 | Calibrated sample valid |
| cal_o | output | 12 | Calibrated, linearized sample |

## Verification
Every result is due three rising edges after the input is captured. This holds for both the data and the valid strobe. The bench drives inputs just after a falling edge and compares outputs on the third falling edge after. It keeps an eight-deep ring of expected results, indexed by the cycle in which each sample was driven. The bench changes its estimate model only for valid samples, in input order. Table writes reach the model at the same falling edge as the sample they must affect. This matches the rule that a write is visible to a sample captured at the same edge.

// File: rtl/bline_pkg.sv
package bline_pkg;

    localparam int SMP_W  = 12;
    localparam int FRAC_W = 4;
    localparam int ACC_W  = SMP_W + FRAC_W;
    localparam int DIFF_W = SMP_W + 2;
    localparam int TBL_N  = 1 << SMP_W;

    typedef logic [SMP_W-1:0] smp_t;
    typedef logic [ACC_W-1:0] acc_t;
    typedef logic signed [DIFF_W-1:0] diff_t;

    typedef struct packed {
        logic vld;
        smp_t val;
    } beat_t;

    function automatic smp_t clamp_addr(input diff_t d);
        smp_t r;
        if (d < 0) begin
            r = '0;
        end else if (d > diff_t'(TBL_N - 1)) begin
            r = '1;
        end else begin
            r = d[SMP_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/bline_in_stage.sv
module bline_in_stage
    import bline_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld_i,
    input  smp_t  smp_i,
    output beat_t beat_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_o <= '0;
        end else begin
            beat_o.vld <= vld_i;
            beat_o.val <= smp_i;
        end
    end

endmodule

// File: rtl/bline_tracker.sv
module bline_tracker
    import bline_pkg::*;
#(
    parameter int QUIET_THR = 64,
    parameter int AVG_SHIFT = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat_i,
    output beat_t addr_o
);

    localparam diff_t THR_S = diff_t'(QUIET_THR);
    localparam int    ERR_W = ACC_W + 2;

    acc_t                     base_q;
    logic                     seeded_q;
    smp_t                     base_int;
    diff_t                    diff;
    logic                     quiet;
    logic signed [ERR_W-1:0]  acc_err;
    logic signed [ERR_W-1:0]  step;
    logic [ERR_W-1:0]         base_nxt;

    always_comb begin
        base_int = base_q[ACC_W-1:FRAC_W];
        diff     = $signed({2'b00, beat_i.val}) - $signed({2'b00, base_int});
        quiet    = (diff < THR_S);
        acc_err  = $signed({2'b00, beat_i.val, {FRAC_W{1'b0}}})
                 - $signed({2'b00, base_q});
        step     = acc_err >>> AVG_SHIFT;
        base_nxt = {2'b00, base_q} + step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            seeded_q <= 1'b0;
            addr_o   <= '0;
        end else begin
            addr_o.vld <= beat_i.vld;
            if (beat_i.vld) begin
                if (!seeded_q) begin
                    base_q     <= {beat_i.val, {FRAC_W{1'b0}}};
                    seeded_q   <= 1'b1;
                    addr_o.val <= '0;
                end else begin
                    addr_o.val <= clamp_addr(diff);
                    if (quiet) begin
                        base_q <= base_nxt[ACC_W-1:0];
                    end
                end
            end
        end
    end

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !beat_i.vld |=> $stable(base_q));

    // R6
    loud_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_i.vld && seeded_q && !quiet) |=> $stable(base_q));

    // R4
    seed_load_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_i.vld && !seeded_q) |=> (base_q[FRAC_W-1:0] == '0 && seeded_q));

    // R5
    avg_range_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_i.vld && seeded_q && quiet) |-> (base_nxt[ERR_W-1:ACC_W] == '0));

    // R5
    avg_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_i.vld && seeded_q && quiet && (beat_i.val > base_int))
            |=> (base_q >= $past(base_q)));

    // R7
    neg_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_i.vld && seeded_q && (diff < 0)) |=> (addr_o.val == '0));

endmodule

// File: rtl/bline_cal_mem.sv
module bline_cal_mem
    import bline_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we_i,
    input  smp_t  waddr_i,
    input  smp_t  wdata_i,
    input  beat_t addr_i,
    output beat_t cal_o
);

    smp_t mem [TBL_N];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_o.vld <= 1'b0;
        end else begin
            cal_o.vld <= addr_i.vld;
        end
        cal_o.val <= mem[addr_i.val];
    end

endmodule

// File: rtl/bline_cond.sv
module bline_cond
    import bline_pkg::*;
#(
    parameter int QUIET_THR = 64,
    parameter int AVG_SHIFT = FRAC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld_i,
    input  logic [SMP_W-1:0] smp_i,
    input  logic             tbl_we_i,
    input  logic [SMP_W-1:0] tbl_addr_i,
    input  logic [SMP_W-1:0] tbl_data_i,
    output logic             cal_vld_o,
    output logic [SMP_W-1:0] cal_o
);

    beat_t s1_beat;
    beat_t s2_addr;
    beat_t s3_cal;

    bline_in_stage u_in (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (smp_vld_i),
        .smp_i  (smp_i),
        .beat_o (s1_beat)
    );

    bline_tracker #(
        .QUIET_THR (QUIET_THR),
        .AVG_SHIFT (AVG_SHIFT)
    ) u_trk (
        .clk    (clk),
        .rst    (rst),
        .beat_i (s1_beat),
        .addr_o (s2_addr)
    );

    bline_cal_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .we_i    (tbl_we_i),
        .waddr_i (tbl_addr_i),
        .wdata_i (tbl_data_i),
        .addr_i  (s2_addr),
        .cal_o   (s3_cal)
    );

    assign cal_vld_o = s3_cal.vld;
    assign cal_o     = s3_cal.val;

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R2
    vld_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) |-> (cal_vld_o == $past(smp_vld_i, 3)));

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !cal_vld_o);

endmodule

// File: tb/bline_cond_tb_top.sv
module bline_cond_tb_top;

    localparam int THR = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld_i = 1'b0;
    logic [11:0] smp_i = '0;
    logic        tbl_we_i = 1'b0;
    logic [11:0] tbl_addr_i = '0;
    logic [11:0] tbl_data_i = '0;
    logic        cal_vld_o;
    logic [11:0] cal_o;

    always #5 clk = ~clk;

    bline_cond #(.QUIET_THR(THR)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .smp_vld_i  (smp_vld_i),
        .smp_i      (smp_i),
        .tbl_we_i   (tbl_we_i),
        .tbl_addr_i (tbl_addr_i),
        .tbl_data_i (tbl_data_i),
        .cal_vld_o  (cal_vld_o),
        .cal_o      (cal_o)
    );

    int    checks = 0;
    int    failures = 0;
    int    tab [4096];
    int    base_m = 0;
    bit    seeded_m = 0;
    bit    ev [8];
    int    ed [8];
    string et [8];
    int    cyc = 0;

    function automatic int cal_fn(int a);
        return ((a * 37) + (a >> 3) + 11) & 12'hFFF;
    endfunction

    function automatic int clamp12(int d);
        if (d < 0) return 0;
        if (d > 4095) return 4095;
        return d;
    endfunction

    function automatic int peek_addr(int s);
        if (!seeded_m) return 0;
        return clamp12(s - (base_m >>> 4));
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(bit v, int s, string tag,
                        bit we = 0, int wa = 0, int wd = 0);
        int k;
        int d;
        int a;
        @(negedge clk);
        if (cyc >= 3) begin
            k = (cyc - 3) % 8;
            check("R2", int'(cal_vld_o), int'(ev[k]));
            if (ev[k]) check(et[k], int'(cal_o), ed[k]);
        end
        smp_vld_i  = v;
        smp_i      = 12'(s);
        tbl_we_i   = we;
        tbl_addr_i = 12'(wa);
        tbl_data_i = 12'(wd);
        if (we) tab[wa] = wd & 12'hFFF;
        k = cyc % 8;
        ev[k] = v;
        if (v) begin
            if (!seeded_m) begin
                a = 0;
                base_m = s * 16;
                seeded_m = 1;
            end else begin
                d = s - (base_m >>> 4);
                a = clamp12(d);
                if (d < THR) base_m = base_m + ((s * 16 - base_m) >>> 4);
            end
            ed[k] = tab[a];
            et[k] = tag;
        end
        cyc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_vld_i = 1'b0;
        tbl_we_i = 1'b0;
        repeat (2) @(negedge clk);
        // R1: valid is low while reset is held
        check("R1", int'(cal_vld_o), 0);
        rst = 1'b0;
        @(negedge clk);
        // R1: still low in the cycle after release
        check("R1", int'(cal_vld_o), 0);
        for (int i = 0; i < 8; i++) ev[i] = 1'b0;
        cyc = 0;
        seeded_m = 0;
        base_m = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned sd;
        int bi;
        int a;
        sd = $urandom(32'd20240611);
        for (int i = 0; i < 4096; i++) tab[i] = 0;
        do_reset();

        // R9: load the whole calibration table while idle
        for (int i = 0; i < 4096; i++) step(0, 0, "R9", 1, i, cal_fn(i));
        repeat (4) step(0, 0, "R2");

        // R4: first sample seeds, looks up address 0
        step(1, 1000, "R4");
        // R5: quiet samples pull the estimate up
        step(1, 1010, "R5");
        step(1, 1010, "R5");
        step(1, 1030, "R5");
        // R6: large deviation leaves estimate alone
        step(1, 1500, "R6");
        step(1, 2000, "R6");
        step(1, 1000, "R6");
        // R7: below estimate clamps to address 0
        step(1, 900, "R7");
        step(1, 0, "R7");
        // R8: idle gap, then same value must give same address
        step(1, 1005, "R8");
        repeat (6) step(0, 4095, "R8");
        step(1, 1005, "R8");
        // R5/R6 threshold boundary
        bi = base_m >>> 4;
        step(1, bi + THR - 1, "R5");
        bi = base_m >>> 4;
        step(1, bi + THR, "R6");
        step(1, bi + THR, "R6");
        // R9: write during streaming, same cycle as the sample using it
        repeat (2) step(0, 0, "R9");
        a = peek_addr(1040);
        step(1, 1040, "R9", 1, a, 12'h5A5);
        step(1, 1040, "R9");
        a = peek_addr(1043);
        step(1, 1043, "R9", 1, a, 12'h0F0);
        repeat (4) step(0, 0, "R2");

        // R4: a second reset reseeds from a new level
        do_reset();
        step(1, 3000, "R4");
        step(1, 3020, "R5");
        step(1, 2900, "R7");

        // R3: randomized traffic around a drifting level with pulses
        for (int i = 0; i < 3000; i++) begin
            int r;
            int s;
            bit v;
            v = (($urandom % 4) != 0);
            r = $urandom % 16;
            if (r == 0) s = $urandom % 4096;
            else        s = 2950 + ($urandom % 81) - 40 + (i / 100);
            step(v, s, "R3");
        end
        repeat (5) step(0, 0, "R2");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule